// File: doc/BRIEF.md
# Page Protection Uniformity Classifier

This block decides whether a whole 4 KiB page of physical memory sees one uniform set of protection rules, so that an address translation cache may hold the page as a single entry. When the protection rules split the page, the cache has to fall back to byte-granular handling and keep no entry. The block receives the page query address together with the already decoded inclusive lower and upper bounds and the match mode of every protection entry. It also receives the number of active rules and a global protection enable.

A request is raised with a one-cycle `start_i` pulse. The block latches the page window and then walks the entries one per cycle, from index 0 upward. Index 0 has the highest priority. The first entry whose range reaches into the page decides the answer. If the entry spans the full page, the answer is "cacheable". If only one of its bounds lands inside the page, the answer is "byte-granular". When no entry reaches the page, or protection is switched off, the page is cacheable. `done_o` pulses once with the answer on `full_page_o`, and the answer stays there until the next pulse.

Top module: `pcc_page_classifier`

## Requirements
- R1: After reset, `done_o` is 0 and `full_page_o` is 1.
- R2: The page window runs from the query address with its low 12 bits cleared up to that value plus 4095. The low 12 bits of the query address do not change the result.
- R3: When `prot_en_i` is 0 or `rule_cnt_i` is 0, an accepted request completes on the clock edge that accepts it, with `full_page_o` = 1 (latency 0).
- R4: An entry whose 2-bit mode is `2'b00` (off) is skipped, even when its bounds touch the page. Any other mode value makes the entry active.
- R5: Entries are examined in ascending index order, one per cycle. Only the first active entry that reaches the page decides the result, whatever the entries above it hold.
- R6: If the first deciding entry k has lower bound ≤ page start and upper bound ≥ page end, the result is 1, with latency k+1 edges after the accepting edge.
- R7: If the first deciding entry k does not cover the page, but its lower or upper bound lies inside the page window, the result is 0, with latency k+1.
- R8: An entry whose bounds are both on or inside the page edges, and that also spans the whole page, counts as covering, so the result is 1.
- R9: If no active entry reaches the page, the result is 1, with latency NUM_ENT (8 by default). No scan lasts longer than that.
- R10: `done_o` is a single-cycle pulse, one per accepted request. A `start_i` during a scan is ignored. `full_page_o` changes only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted when no scan is running |
| query_addr_i | input | ADDR_W | Address inside the page to classify |
| prot_en_i | input | 1 | Protection enable |
| rule_cnt_i | input | CNT_W | Number of active rules |
| ent_lo_i | input | NUM_ENT*ADDR_W | Inclusive lower bounds, entry i at bits [i*ADDR_W +: ADDR_W] |
| ent_hi_i | input | NUM_ENT*ADDR_W | Inclusive upper bounds, same packing |
| ent_mode_i | input | NUM_ENT*2 | Match mode per entry, 2'b00 = off |
| done_o | output | 1 | One-cycle completion pulse |
| full_page_o | output | 1 | 1 = page cacheable as a whole, 0 = byte-granular |

## Verification
Two decisions can fall in the same evaluation cycle. One case is a single entry that both spans the page and has a bound exactly on a page edge, so the "covers" and "touches" tests are both true at once. The bench provokes this with an entry that equals the page exactly, and with one that stops a single byte short of the page end. It expects full page for the first and byte-granular for the second. The other case is a new `start_i` arriving while a scan is running. The bench injects a disabled-protection request mid-scan and expects exactly one completion, carrying the first request's result and latency.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic {
        PCC_IDLE = 1'b0,
        PCC_SCAN = 1'b1
    } pcc_state_e;

    localparam int MODE_W = 2;
    typedef logic [MODE_W-1:0] pcc_mode_t;
    localparam pcc_mode_t MODE_OFF = 2'b00;

endpackage

// File: rtl/pcc_page_window.sv
module pcc_page_window #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] last_o
);
    localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    always_comb begin
        first_o = addr_i & ~OFFS_MASK;
        last_o  = addr_i | OFFS_MASK;
    end
endmodule

// File: rtl/pcc_entry_match.sv
module pcc_entry_match
    import pcc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    input  pcc_mode_t         mode_i,
    input  logic [ADDR_W-1:0] pg_first_i,
    input  logic [ADDR_W-1:0] pg_last_i,
    output logic              active_o,
    output logic              covers_o,
    output logic              touches_o
);
    logic lo_in_page;
    logic hi_in_page;

    always_comb begin
        active_o   = (mode_i != MODE_OFF);
        lo_in_page = (lo_i >= pg_first_i) && (lo_i <= pg_last_i);
        hi_in_page = (hi_i >= pg_first_i) && (hi_i <= pg_last_i);
        covers_o   = (lo_i <= pg_first_i) && (hi_i >= pg_last_i);
        touches_o  = lo_in_page || hi_in_page;
    end
endmodule

// File: rtl/pcc_page_classifier.sv
module pcc_page_classifier
    import pcc_pkg::*;
#(
    parameter int NUM_ENT    = 8,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int CNT_W      = $clog2(NUM_ENT + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ADDR_W-1:0]           query_addr_i,
    input  logic                        prot_en_i,
    input  logic [CNT_W-1:0]            rule_cnt_i,
    input  logic [NUM_ENT*ADDR_W-1:0]   ent_lo_i,
    input  logic [NUM_ENT*ADDR_W-1:0]   ent_hi_i,
    input  logic [NUM_ENT*MODE_W-1:0]   ent_mode_i,
    output logic                        done_o,
    output logic                        full_page_o
);
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENT - 1);

    typedef struct packed {
        pcc_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] pg_first;
        logic [ADDR_W-1:0] pg_last;
        logic              done;
        logic              full;
    } pcc_regs_t;

    pcc_regs_t d, q;

    logic [ADDR_W-1:0]  win_first_w;
    logic [ADDR_W-1:0]  win_last_w;
    logic [NUM_ENT-1:0] active_w;
    logic [NUM_ENT-1:0] covers_w;
    logic [NUM_ENT-1:0] touches_w;

    pcc_page_window #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_window (
        .addr_i (query_addr_i),
        .first_o(win_first_w),
        .last_o (win_last_w)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        pcc_entry_match #(
            .ADDR_W(ADDR_W)
        ) u_match (
            .lo_i      (ent_lo_i[g*ADDR_W +: ADDR_W]),
            .hi_i      (ent_hi_i[g*ADDR_W +: ADDR_W]),
            .mode_i    (ent_mode_i[g*MODE_W +: MODE_W]),
            .pg_first_i(q.pg_first),
            .pg_last_i (q.pg_last),
            .active_o  (active_w[g]),
            .covers_o  (covers_w[g]),
            .touches_o (touches_w[g])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            PCC_IDLE: begin
                if (start_i) begin
                    d.pg_first = win_first_w;
                    d.pg_last  = win_last_w;
                    d.idx      = '0;
                    if (!prot_en_i || (rule_cnt_i == '0)) begin
                        d.done = 1'b1;
                        d.full = 1'b1;
                    end else begin
                        d.state = PCC_SCAN;
                    end
                end
            end
            PCC_SCAN: begin
                if (active_w[q.idx] && covers_w[q.idx]) begin
                    d.done  = 1'b1;
                    d.full  = 1'b1;
                    d.state = PCC_IDLE;
                end else if (active_w[q.idx] && touches_w[q.idx]) begin
                    d.done  = 1'b1;
                    d.full  = 1'b0;
                    d.state = PCC_IDLE;
                end else if (q.idx == LAST_IDX) begin
                    d.done  = 1'b1;
                    d.full  = 1'b1;
                    d.state = PCC_IDLE;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.state = PCC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= PCC_IDLE;
            q.idx      <= '0;
            q.pg_first <= '0;
            q.pg_last  <= '0;
            q.done     <= 1'b0;
            q.full     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done_o      = q.done;
    assign full_page_o = q.full;

endmodule

// File: rtl/pcc_page_classifier_chk.sv
module pcc_page_classifier_chk #(
    parameter int NUM_ENT = 8,
    parameter int CNT_W   = $clog2(NUM_ENT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             prot_en_i,
    input logic [CNT_W-1:0] rule_cnt_i,
    input logic             done_o,
    input logic             full_page_o
);
    localparam int LEN_W = $clog2(NUM_ENT + 2) + 1;

    logic             scan_q;
    logic [LEN_W-1:0] len_q;
    logic             accepted;
    logic             work;

    assign accepted = start_i && (!scan_q || done_o);
    assign work     = prot_en_i && (rule_cnt_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= 1'b0;
            len_q  <= '0;
        end else begin
            if (accepted)    scan_q <= work;
            else if (done_o) scan_q <= 1'b0;
            len_q <= (scan_q && !done_o) ? len_q + 1'b1 : '0;
        end
    end

    p_shortcut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accepted && !work |=> done_o && full_page_o);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> !done_o);

    p_done_needs_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (scan_q || $past(start_i)));

    p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(full_page_o));

    p_scan_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_W'(NUM_ENT));

endmodule

bind pcc_page_classifier pcc_page_classifier_chk #(
    .NUM_ENT(NUM_ENT),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .prot_en_i  (prot_en_i),
    .rule_cnt_i (rule_cnt_i),
    .done_o     (done_o),
    .full_page_o(full_page_o)
);

// File: tb/pcc_page_classifier_bench.sv
module pcc_page_classifier_bench;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int CW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] qaddr = '0;
    logic en = 1'b1;
    logic [CW-1:0] cnt = CW'(N);
    logic [AW-1:0] lo [N];
    logic [AW-1:0] hi [N];
    logic [1:0]    md [N];
    logic [N*AW-1:0] lo_flat, hi_flat;
    logic [N*2-1:0]  md_flat;
    logic done, full;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            lo_flat[i*AW +: AW] = lo[i];
            hi_flat[i*AW +: AW] = hi[i];
            md_flat[i*2 +: 2]   = md[i];
        end
    end

    pcc_page_classifier #(.NUM_ENT(N), .ADDR_W(AW)) u_pcc_page_classifier (
        .clk(clk), .rst_n(rst_n), .start_i(start), .query_addr_i(qaddr),
        .prot_en_i(en), .rule_cnt_i(cnt), .ent_lo_i(lo_flat), .ent_hi_i(hi_flat),
        .ent_mode_i(md_flat), .done_o(done), .full_page_o(full));

    typedef struct {
        bit    full;
        int    lat;
        int    start_cyc;
        string tag;
    } exp_t;

    exp_t q_exp[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_issued = 0;
    int   n_done = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (rst_n && done) begin
                n_done++;
                if (q_exp.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    int   lat;
                    e   = q_exp.pop_front();
                    lat = cyc - e.start_cyc - 1;
                    check(full == e.full, {e.tag, " result"}, int'(full), int'(e.full));
                    check(lat == e.lat, {e.tag, " latency"}, lat, e.lat);
                end
            end
        end
    end

    task automatic clear_entries();
        for (int i = 0; i < N; i++) begin
            lo[i] = '0;
            hi[i] = '0;
            md[i] = 2'b00;
        end
    endtask

    task automatic set_ent(input int i, input logic [AW-1:0] l, input logic [AW-1:0] h,
                           input logic [1:0] m);
        lo[i] = l;
        hi[i] = h;
        md[i] = m;
    endtask

    task automatic request(input logic [AW-1:0] a, input bit exp_full, input int exp_lat,
                           input string tag);
        exp_t e;
        @(negedge clk);
        qaddr = a;
        start = 1'b1;
        e.full = exp_full;
        e.lat = exp_lat;
        e.start_cyc = cyc;
        e.tag = tag;
        q_exp.push_back(e);
        n_issued++;
        @(negedge clk);
        start = 1'b0;
        while (n_done < n_issued) @(negedge clk);
    endtask

    localparam logic [AW-1:0] PG = 32'h0001_2345; // page 0x12000..0x12FFF

    initial begin
        clear_entries();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(full == 1'b1, "R1 result after reset", int'(full), 1);

        // R6 / R2: entry 3 spans the page, offset bits in query address
        clear_entries();
        set_ent(3, 32'h0001_0000, 32'h0001_FFFF, 2'b11);
        request(PG, 1'b1, 4, "R6 cover at entry 3");
        request(32'h0001_2FFF, 1'b1, 4, "R2 offset bits ignored");
        request(32'h0003_2000, 1'b1, 8, "R2 other page untouched");

        // R7 variants
        clear_entries();
        set_ent(2, 32'h0001_2800, 32'h0001_3FFF, 2'b01);
        request(PG, 1'b0, 3, "R7 lower bound inside");
        clear_entries();
        set_ent(0, 32'h0001_1000, 32'h0001_2010, 2'b10);
        request(PG, 1'b0, 1, "R7 upper bound inside");
        clear_entries();
        set_ent(5, 32'h0001_2100, 32'h0001_21FF, 2'b11);
        request(PG, 1'b0, 6, "R7 range within page");

        // R5 priority
        clear_entries();
        set_ent(1, 32'h0001_2F00, 32'h0001_5000, 2'b01);
        set_ent(4, 32'h0000_0000, 32'h00FF_FFFF, 2'b01);
        request(PG, 1'b0, 2, "R5 partial wins over later cover");
        clear_entries();
        set_ent(1, 32'h0000_0000, 32'h00FF_FFFF, 2'b01);
        set_ent(4, 32'h0001_2F00, 32'h0001_5000, 2'b01);
        request(PG, 1'b1, 2, "R5 cover wins over later partial");

        // R4 off entry skipped
        clear_entries();
        set_ent(0, 32'h0001_2100, 32'h0001_21FF, 2'b00);
        set_ent(6, 32'h0001_0000, 32'h0001_FFFF, 2'b10);
        request(PG, 1'b1, 7, "R4 off entry skipped");

        // R9 nothing reaches the page, bounds one byte outside
        clear_entries();
        for (int i = 0; i < N; i++) begin
            if (i % 2 == 0) set_ent(i, 32'h0000_0000, 32'h0001_1FFF, 2'b01);
            else            set_ent(i, 32'h0001_3000, 32'h0002_0000, 2'b11);
        end
        request(PG, 1'b1, 8, "R9 no entry reaches page");

        // R8 exact page span vs one byte short
        clear_entries();
        set_ent(0, 32'h0001_2000, 32'h0001_2FFF, 2'b01);
        request(PG, 1'b1, 1, "R8 exact page span covers");
        set_ent(0, 32'h0001_2000, 32'h0001_2FFE, 2'b01);
        request(PG, 1'b0, 1, "R8 one byte short is partial");

        // R3 shortcuts with a touching entry present
        clear_entries();
        set_ent(0, 32'h0001_2100, 32'h0001_21FF, 2'b11);
        en = 1'b0;
        request(PG, 1'b1, 0, "R3 protection disabled");
        en = 1'b1;
        cnt = '0;
        request(PG, 1'b1, 0, "R3 zero rule count");
        cnt = CW'(N);

        // R10 start during a scan is ignored
        clear_entries();
        set_ent(7, 32'h0001_0000, 32'h0001_FFFF, 2'b01);
        begin
            exp_t e;
            @(negedge clk);
            qaddr = PG;
            start = 1'b1;
            e.full = 1'b1;
            e.lat = 8;
            e.start_cyc = cyc;
            e.tag = "R10 start during scan ignored";
            q_exp.push_back(e);
            n_issued++;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
            en = 1'b0;
            qaddr = 32'h0009_0000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            en = 1'b1;
            while (n_done < n_issued) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(n_done == n_issued, "R10 one done per request", n_done, n_issued);
        check(done == 1'b0, "R10 no stray pulse", int'(done), 0);

        finish_run();
    end

    initial begin
        #200000;
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end
endmodule